// File: doc/BRIEF.md
# 1-Wire Bus Master Sequencer

This block is the bus master for a single open-drain 1-Wire line. A host issues one transaction at a time: a start strobe with an opcode and, for writes, a data byte. The block then plays the matching sequence of slots on the line. Five transactions are available: bus reset with presence detection, single-bit write, single-bit read, byte write and byte read. While a transaction runs, `busy` is high. A one-clock `done` pulse marks its end, with the read data or the presence flag valid in that same cycle.

Each slot is assembled from one set of ten named intervals, A to J, counted in microsecond ticks. The tick comes from dividing the system clock by `CLK_PER_US`. A speed register chooses between a standard-speed set and an overdrive set of those intervals. The block can only pull the line low (`ow_oe`). An external pull-up supplies the high level. The line is read back on `ow_in` through a two-flop synchronizer.

Top module: `ow_master`

## Requirements
- R1: A reset transaction first waits G. It then pulls the line low for exactly H microseconds (H*CLK_PER_US clocks) and releases it. After waiting I it samples the line, then waits J before `done`. The whole transaction takes (G+H+I+J)*CLK_PER_US clocks plus a few clocks of overhead.
- R2: `presence` at the end of a reset is the inverse of the sampled line. A low line at the sample point gives `presence`=1, and a high line gives 0.
- R3: Writing a 1 pulls the line low for A and then releases it for B. Writing a 0 pulls it low for C and then releases it for D. The bit written by opcode 1 is `din[0]`.
- R4: A read slot pulls the line low for A and releases it. After E it samples the synchronized line, then waits F. Opcode 2 returns the sampled bit in `dout[0]`, with the upper bits of `dout` cleared.
- R5: A byte write (opcode 3) sends eight write slots, `din[0]` first and `din[7]` last.
- R6: A byte read (opcode 4) runs eight read slots. Each new bit is shifted in at the top, so the first bit received ends up in `dout[0]`.
- R7: After reset the block runs at standard speed: A..J = 6,64,60,10,9,55,0,480,70,410 µs. A `spd_wr` pulse selects overdrive if `spd_val` is nonzero: A..J = 1,7,7,2,1,7,2,70,8,40 µs. The same pulse with `spd_val` = 0 selects standard speed. A `spd_wr` pulse while `busy` is high is ignored. A speed change never alters a transaction already started.
- R8: The block never drives the line high. `ow_oe` is the only drive, it pulls the line low, and it is 0 whenever `busy` is 0.
- R9: `done` is high for exactly one clock per transaction. `busy` is already 0 in that cycle.
- R10: The opcodes are 0 reset, 1 write bit, 2 read bit, 3 write byte and 4 read byte. A start with opcode 5, 6 or 7 is ignored: `busy` stays low, there is no `done`, and the line is not touched. A start while `busy` is high is ignored as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction when idle |
| op | input | 3 | Transaction opcode |
| din | input | BYTE_W | Write data (bit 0 for single-bit write) |
| spd_wr | input | 1 | Speed configuration strobe |
| spd_val | input | SPD_W | Speed value, nonzero selects overdrive |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock end-of-transaction pulse |
| dout | output | BYTE_W | Read bit or byte, valid with done |
| presence | output | 1 | Presence flag from the last reset |
| ow_oe | output | 1 | Pull line low when 1, release when 0 |
| ow_in | input | 1 | Sampled line level |

## Verification
A wrong phase index or interval counter shows up within the first slot of a transaction: the width of the low pulse on `ow_oe` no longer matches A, C or H times `CLK_PER_US`. A wrong shift or bit counter shows up at the `done` of the same byte, either as a reordered `dout` or as a written bit sequence that does not rebuild `din`. A speed register that changes at the wrong time shows up in the first slot of the next transaction, where the low width comes from the other interval set. A bad idle-state decode shows up immediately as `ow_oe` active, or as `busy` rising, while the block should be idle.

// File: rtl/ow_pkg.sv
package ow_pkg;

    localparam int US_W = 16;
    localparam int NPH  = 4;

    typedef enum logic [2:0] {
        OP_RST   = 3'd0,
        OP_WBIT  = 3'd1,
        OP_RBIT  = 3'd2,
        OP_WBYTE = 3'd3,
        OP_RBYTE = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        SK_RST = 2'd0,
        SK_W1  = 2'd1,
        SK_W0  = 2'd2,
        SK_RD  = 2'd3
    } slot_e;

    typedef struct packed {
        logic [US_W-1:0] a, b, c, d, e, f, g, h, i, j;
    } timing_t;

    typedef struct packed {
        logic            low;
        logic            smp;
        logic [US_W-1:0] dur;
    } phase_t;

    function automatic timing_t timing_for(input logic od);
        timing_t t;
        if (od) begin
            t.a = 16'd1;  t.b = 16'd7;  t.c = 16'd7;  t.d = 16'd2;  t.e = 16'd1;
            t.f = 16'd7;  t.g = 16'd2;  t.h = 16'd70; t.i = 16'd8;  t.j = 16'd40;
        end else begin
            t.a = 16'd6;  t.b = 16'd64; t.c = 16'd60; t.d = 16'd10; t.e = 16'd9;
            t.f = 16'd55; t.g = 16'd0;  t.h = 16'd480; t.i = 16'd70; t.j = 16'd410;
        end
        return t;
    endfunction

    function automatic logic op_legal(input logic [2:0] o);
        return (o <= 3'd4);
    endfunction

    // Phase descriptor: line low flag, sample-at-end flag, duration in us.
    function automatic phase_t phase_of(input slot_e k, input timing_t t, input logic [1:0] idx);
        phase_t p;
        p.low = 1'b0;
        p.smp = 1'b0;
        p.dur = '0;
        case (k)
            SK_RST: case (idx)
                2'd0: p.dur = t.g;
                2'd1: begin p.low = 1'b1; p.dur = t.h; end
                2'd2: begin p.smp = 1'b1; p.dur = t.i; end
                default: p.dur = t.j;
            endcase
            SK_W1: case (idx)
                2'd0: begin p.low = 1'b1; p.dur = t.a; end
                2'd1: p.dur = t.b;
                default: p.dur = '0;
            endcase
            SK_W0: case (idx)
                2'd0: begin p.low = 1'b1; p.dur = t.c; end
                2'd1: p.dur = t.d;
                default: p.dur = '0;
            endcase
            default: case (idx)
                2'd0: begin p.low = 1'b1; p.dur = t.a; end
                2'd1: begin p.smp = 1'b1; p.dur = t.e; end
                2'd2: p.dur = t.f;
                default: p.dur = '0;
            endcase
        endcase
        return p;
    endfunction

    // First phase at or after 'from' with a nonzero duration; 4 means none.
    function automatic logic [2:0] next_ph(input slot_e k, input timing_t t, input logic [2:0] from);
        logic [2:0] r;
        r = 3'd4;
        for (int n = NPH - 1; n >= 0; n--) begin
            if (3'(n) >= from && phase_of(k, t, 2'(n)).dur != '0)
                r = 3'(n);
        end
        return r;
    endfunction

endpackage

// File: rtl/ow_sync2.sv
module ow_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R1: ticks are spaced one microsecond apart
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        (CLK_PER_US > 1 && tick && !clr) |=> !tick);
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
    import ow_pkg::*;
#(
    parameter int CLK_PER_US = 50
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    go,
    input  slot_e   kind_i,
    input  timing_t tim_i,
    input  logic    line_s,
    output logic    oe,
    output logic    fin,
    output logic    bit_o
);
    logic            act;
    logic [1:0]      ph;
    slot_e           kind_q;
    timing_t         tim_q;
    logic [US_W-1:0] us_cnt;
    logic            bit_q;
    logic            fin_q;
    logic            tick;
    logic            tclr;
    logic            phase_end;
    phase_t          cur;
    logic [2:0]      first_ph;
    logic [2:0]      nxt_ph;

    assign cur       = phase_of(kind_q, tim_q, ph);
    assign first_ph  = next_ph(kind_i, tim_i, 3'd0);
    assign nxt_ph    = next_ph(kind_q, tim_q, {1'b0, ph} + 3'd1);
    assign phase_end = act && tick && (us_cnt == cur.dur - 16'd1);
    assign tclr      = go || phase_end;

    ow_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (tclr),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= 1'b0;
            ph     <= '0;
            kind_q <= SK_RST;
            tim_q  <= '0;
            us_cnt <= '0;
            bit_q  <= 1'b1;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                kind_q <= kind_i;
                tim_q  <= tim_i;
                us_cnt <= '0;
                bit_q  <= 1'b1;
                if (first_ph[2]) begin
                    fin_q <= 1'b1;
                end else begin
                    act <= 1'b1;
                    ph  <= first_ph[1:0];
                end
            end else if (act) begin
                if (phase_end) begin
                    if (cur.smp)
                        bit_q <= line_s;
                    us_cnt <= '0;
                    if (nxt_ph[2]) begin
                        act   <= 1'b0;
                        fin_q <= 1'b1;
                    end else begin
                        ph <= nxt_ph[1:0];
                    end
                end else if (tick) begin
                    us_cnt <= us_cnt + 16'd1;
                end
            end
        end
    end

    assign oe    = act && cur.low;
    assign fin   = fin_q;
    assign bit_o = bit_q;

    // R3: the microsecond count never reaches the current interval length
    p_us_bound_r3: assert property (@(posedge clk) disable iff (rst)
        act |-> (us_cnt < cur.dur));

    // R1: a launched slot is active or finished on the next cycle
    p_go_starts_r1: assert property (@(posedge clk) disable iff (rst)
        go |=> (act || fin));
endmodule

// File: rtl/ow_master.sv
module ow_master
    import ow_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int BYTE_W     = 8,
    parameter int SPD_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [BYTE_W-1:0] din,
    input  logic              spd_wr,
    input  logic [SPD_W-1:0]  spd_val,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] dout,
    output logic              presence,
    output logic              ow_oe,
    input  logic              ow_in
);
    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

    logic              busy_q, done_q, go_q, spd_q, pres_q;
    logic [2:0]        op_q;
    logic [BYTE_W-1:0] sh_q, dout_q, sh_next;
    logic [IDX_W-1:0]  idx_q;
    timing_t           tim_q;
    slot_e             kind;
    logic              line_s, fin, slot_bit;
    logic              is_read, is_multi;

    ow_sync2 u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ow_in),
        .q   (line_s)
    );

    assign is_read  = (op_q == OP_RBIT) || (op_q == OP_RBYTE);
    assign is_multi = (op_q == OP_WBYTE) || (op_q == OP_RBYTE);

    always_comb begin
        if (op_q == OP_RST)
            kind = SK_RST;
        else if (is_read)
            kind = SK_RD;
        else if (sh_q[0])
            kind = SK_W1;
        else
            kind = SK_W0;
    end

    always_comb begin
        if (is_read)
            sh_next = {slot_bit, sh_q[BYTE_W-1:1]};
        else
            sh_next = {1'b0, sh_q[BYTE_W-1:1]};
    end

    ow_slot_engine #(.CLK_PER_US(CLK_PER_US)) u_slot (
        .clk    (clk),
        .rst    (rst),
        .go     (go_q),
        .kind_i (kind),
        .tim_i  (tim_q),
        .line_s (line_s),
        .oe     (ow_oe),
        .fin    (fin),
        .bit_o  (slot_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            go_q   <= 1'b0;
            spd_q  <= 1'b0;
            pres_q <= 1'b0;
            op_q   <= 3'd0;
            sh_q   <= '0;
            dout_q <= '0;
            idx_q  <= '0;
            tim_q  <= '0;
        end else begin
            done_q <= 1'b0;
            go_q   <= 1'b0;
            if (spd_wr && !busy_q)
                spd_q <= |spd_val;
            if (!busy_q) begin
                if (start && op_legal(op)) begin
                    busy_q <= 1'b1;
                    op_q   <= op;
                    sh_q   <= din;
                    idx_q  <= '0;
                    tim_q  <= timing_for(spd_q);
                    go_q   <= 1'b1;
                end
            end else if (fin) begin
                sh_q <= sh_next;
                if (is_multi && idx_q != LAST_IDX) begin
                    idx_q <= idx_q + 1'b1;
                    go_q  <= 1'b1;
                end else begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    if (op_q == OP_RST)
                        pres_q <= ~slot_bit;
                    else if (op_q == OP_RBIT)
                        dout_q <= {{(BYTE_W-1){1'b0}}, slot_bit};
                    else if (op_q == OP_RBYTE)
                        dout_q <= sh_next;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign dout     = dout_q;
    assign presence = pres_q;

    // R8: the line is released whenever the block is idle
    p_idle_release_r8: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !ow_oe);

    // R9: done lasts a single clock
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R9: busy is already low when done is reported
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q);

    // R7: the speed selection holds for the whole transaction
    p_speed_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(spd_q));

    // R10: an undefined opcode does not start a transaction
    p_bad_op_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && start && !op_legal(op)) |=> !busy_q);
endmodule

// File: tb/sim_ow_master.sv
module sim_ow_master;
    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 4;
    localparam int STD_T[10]  = '{6, 64, 60, 10, 9, 55, 0, 480, 70, 410};
    localparam int OD_T[10]   = '{1, 7, 7, 2, 1, 7, 2, 70, 8, 40};
    localparam int IA = 0, IC = 2, IE = 4, IG = 6, IH = 7, II = 8, IJ = 9;

    typedef struct packed {
        logic       od;
        logic [2:0] op;
        logic [7:0] din;
        logic [1:0] dm;   // 0 none, 1 presence, 2 read responder, 3 write logger
        logic [7:0] db;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VEC[11] = '{
        '{1'b0, 3'd0, 8'h00, 2'd1, 8'h00, 8'h01},
        '{1'b0, 3'd0, 8'h00, 2'd0, 8'h00, 8'h00},
        '{1'b0, 3'd3, 8'hA5, 2'd3, 8'h00, 8'hA5},
        '{1'b0, 3'd4, 8'h00, 2'd2, 8'h3C, 8'h3C},
        '{1'b0, 3'd1, 8'h01, 2'd3, 8'h00, 8'h01},
        '{1'b0, 3'd2, 8'h00, 2'd2, 8'h00, 8'h00},
        '{1'b1, 3'd0, 8'h00, 2'd1, 8'h00, 8'h01},
        '{1'b1, 3'd3, 8'h5A, 2'd3, 8'h00, 8'h5A},
        '{1'b1, 3'd4, 8'h00, 2'd2, 8'hC3, 8'hC3},
        '{1'b1, 3'd2, 8'h00, 2'd2, 8'h01, 8'h01},
        '{1'b0, 3'd1, 8'h00, 2'd3, 8'h00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] op = 3'd0;
    logic [7:0] din = 8'h00;
    logic       spd_wr = 1'b0;
    logic [7:0] spd_val = 8'h00;
    logic       busy, done, presence, ow_oe, ow_in;
    logic [7:0] dout;

    int   checks = 0;
    int   failures = 0;
    logic cur_od = 1'b0;
    int   dev_mode = 0;
    logic [7:0] dev_byte = 8'h00;
    logic arm = 1'b0;

    logic       oe_q;
    int         lowcnt, last_low, hold, rd_idx, wr_cnt, wr_bad, viol, done_cnt;
    logic [7:0] wr_byte;
    logic       dev_low;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ow_master #(.CLK_PER_US(CPU)) u0 (
        .clk(clk), .rst(rst), .start(start), .op(op), .din(din),
        .spd_wr(spd_wr), .spd_val(spd_val), .busy(busy), .done(done),
        .dout(dout), .presence(presence), .ow_oe(ow_oe), .ow_in(ow_in)
    );

    assign dev_low = (hold > 0);
    assign ow_in   = ~(ow_oe | dev_low);

    function automatic int tv(input logic od, input int idx);
        return od ? OD_T[idx] : STD_T[idx];
    endfunction

    // Device model: measures low pulses, logs written bits, answers reads and resets.
    always_ff @(posedge clk) begin
        if (rst || arm) begin
            oe_q <= 1'b0; lowcnt <= 0; last_low <= 0; hold <= 0;
            rd_idx <= 0; wr_cnt <= 0; wr_bad <= 0; wr_byte <= 8'h00;
        end else begin
            oe_q <= ow_oe;
            if (hold > 0) hold <= hold - 1;
            if (ow_oe && !oe_q) begin
                lowcnt <= 1;
                if (dev_mode == 2) begin
                    rd_idx <= rd_idx + 1;
                    if (!dev_byte[rd_idx[2:0]])
                        hold <= (tv(cur_od, IA) + tv(cur_od, IE) + 2) * CPU;
                end
            end else if (ow_oe) begin
                lowcnt <= lowcnt + 1;
            end else if (oe_q) begin
                last_low <= lowcnt;
                if (dev_mode == 1)
                    hold <= (tv(cur_od, II) + 10) * CPU;
                if (dev_mode == 3) begin
                    if (lowcnt == tv(cur_od, IA) * CPU) begin
                        wr_byte[wr_cnt[2:0]] <= 1'b1; wr_cnt <= wr_cnt + 1;
                    end else if (lowcnt == tv(cur_od, IC) * CPU) begin
                        wr_byte[wr_cnt[2:0]] <= 1'b0; wr_cnt <= wr_cnt + 1;
                    end else begin
                        wr_bad <= wr_bad + 1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol <= 0; done_cnt <= 0;
        end else begin
            if (ow_oe && !busy) viol <= viol + 1;
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_speed(input logic od);
        @(negedge clk);
        spd_wr = 1'b1;
        spd_val = od ? 8'h80 : 8'h00;
        @(negedge clk);
        spd_wr = 1'b0;
        cur_od = od;
    endtask

    task automatic run(input logic [2:0] o, input logic [7:0] d, input int dm,
                       input logic [7:0] db, output int span);
        @(negedge clk);
        dev_mode = dm; dev_byte = db; arm = 1'b1;
        start = 1'b1; op = o; din = d;
        @(negedge clk);
        start = 1'b0; arm = 1'b0;
        span = 1;
        while (!done && span < 60000) begin
            @(negedge clk);
            span++;
        end
        chk("R9 done reached", int'(done), 1);
        chk("R9 busy low with done", int'(busy), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int span, dc, lo;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset busy", int'(busy), 0);
        chk("R9 reset done", int'(done), 0);
        chk("R8 reset oe", int'(ow_oe), 0);
        chk("R2 reset presence", int'(presence), 0);
        chk("R6 reset dout", int'(dout), 0);

        // Table-driven transactions
        for (int k = 0; k < 11; k++) begin
            if (VEC[k].od != cur_od) set_speed(VEC[k].od);
            run(VEC[k].op, VEC[k].din, int'(VEC[k].dm), VEC[k].db, span);
            @(negedge clk);
            chk("R9 done single cycle", int'(done), 0);
            case (VEC[k].op)
                3'd0: begin
                    chk("R2 presence", int'(presence), int'(VEC[k].exp[0]));
                    chk("R1 reset low width", last_low, tv(cur_od, IH) * CPU);
                    lo = (tv(cur_od, IG) + tv(cur_od, IH) + tv(cur_od, II) + tv(cur_od, IJ)) * CPU;
                    chk("R1 reset span", int'(span >= lo && span <= lo + 10), 1);
                end
                3'd1: begin
                    chk("R3 bit count", wr_cnt, 1);
                    chk("R3 bit value", int'(wr_byte[0]), int'(VEC[k].din[0]));
                    chk("R3 low width", last_low,
                        tv(cur_od, VEC[k].din[0] ? IA : IC) * CPU);
                end
                3'd2: chk("R4 read bit", int'(dout), int'(VEC[k].exp));
                3'd3: begin
                    chk("R5 slot count", wr_cnt, 8);
                    chk("R5 bad widths", wr_bad, 0);
                    chk("R5 byte order", int'(wr_byte), int'(VEC[k].exp));
                end
                default: chk("R6 read byte", int'(dout), int'(VEC[k].exp));
            endcase
        end

        // R10: undefined opcode ignored
        dc = done_cnt;
        @(negedge clk);
        start = 1'b1; op = 3'd6; din = 8'hFF;
        @(negedge clk);
        start = 1'b0;
        repeat (5) begin
            @(negedge clk);
            if (busy || ow_oe) chk("R10 bad opcode idle", 1, 0);
        end
        chk("R10 bad opcode no busy", int'(busy), 0);
        chk("R10 bad opcode no done", done_cnt - dc, 0);

        // R10 and R7: start and speed write while busy both ignored
        dc = done_cnt;
        @(negedge clk);
        dev_mode = 3; arm = 1'b1; start = 1'b1; op = 3'd1; din = 8'h00;
        @(negedge clk);
        arm = 1'b0; start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1; op = 3'd0; spd_wr = 1'b1; spd_val = 8'h01;
        @(negedge clk);
        start = 1'b0; spd_wr = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R10 one done only", done_cnt - dc, 1);
        chk("R10 no reset pulse", last_low, STD_T[IC] * CPU);
        run(3'd1, 8'h01, 3, 8'h00, span);
        chk("R7 speed unchanged after busy write", last_low, STD_T[IA] * CPU);

        // R7: overdrive write then back to standard
        set_speed(1'b1);
        run(3'd1, 8'h01, 3, 8'h00, span);
        chk("R7 overdrive write1 width", last_low, OD_T[IA] * CPU);
        set_speed(1'b0);
        run(3'd1, 8'h00, 3, 8'h00, span);
        chk("R7 standard write0 width", last_low, STD_T[IC] * CPU);

        chk("R8 oe only while busy", viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule